// File: doc/BRIEF.md
# Two-Bank Clock Buffer Mode Controller

This block holds the digital control of an eight-output clock fan-out buffer. The outputs form two banks of four, and all outputs in a bank carry the same clock. A two-bit mode input sets, for each bank, whether it drives or floats. The same input sets whether the loop oscillator runs as the clock source, is bypassed so that the outputs copy the reference, or is shut down. The block produces per-bank drive enables, a source select, an oscillator enable and a bank B half-rate phase. The analog loop and the output drivers sit outside it. The loop clock comes in as a plain input.

The block samples the reference with a free-running sample clock. If the reference stops rising for a set number of sample cycles, the block forces a power-down that overrides the mode input. Whenever the oscillator has been off, the banks stay disabled in the oscillator-sourced modes until a lock wait has run out. The mode input passes through a two-flop synchronizer before it is decoded. An optional divide-by-two in the bank B path makes bank B run at half the source rate. Its flop is cleared while bank B is off, so it starts from a known phase.

Top module: `clkbuf_mode_ctrl`

## Requirements
- R1: During and right after synchronous reset, every output is 0.
- R2: Mode code 00 gives bank_a_oe=0, bank_b_oe=0, pll_enable=0 and src_pll=0.
- R3: Mode code 01 gives pll_enable=1, src_pll=1 and bank_b_oe=0. bank_a_oe=1 once the loop is locked.
- R4: Mode code 10 (bypass) gives bank_a_oe=1, bank_b_oe=1, pll_enable=0 and src_pll=0, with no lock wait.
- R5: Mode code 11 gives pll_enable=1 and src_pll=1, and both bank enables once locked. bank_b_oe is never 1 while bank_a_oe is 0.
- R6: The block powers down after IDLE_TIMEOUT consecutive sample cycles with no synchronized rising edge on ref_clk. In power-down it drives all enables, pll_enable and src_pll to 0, whatever the mode code.
- R7: The first synchronized ref_clk rising edge after a timeout clears the power-down. The reference passes two synchronizer flops and one edge flop.
- R8: The lock counter restarts whenever pll_enable is off. In codes 01 and 11 the banks enable only after LOCK_WAIT cycles with the oscillator running.
- R9: A new mode code reaches the outputs on the third rising clock edge after it is applied, and not before.
- R10: With b_half_en=1 and bank B enabled, bank_b_half toggles on each synchronized rising edge of the selected source: pll_clk when src_pll=1, otherwise ref_clk. It is 0 whenever bank B is disabled or b_half_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sample clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock, asynchronous |
| pll_clk | input | 1 | Loop oscillator clock, asynchronous |
| sel | input | 2 | Mode code, asynchronous |
| b_half_en | input | 1 | Enables bank B divide-by-two |
| bank_a_oe | output | 1 | Bank A drive enable |
| bank_b_oe | output | 1 | Bank B drive enable |
| src_pll | output | 1 | 1 selects the loop clock, 0 the reference |
| pll_enable | output | 1 | Loop oscillator enable |
| bank_b_half | output | 1 | Bank B half-rate phase |

## Verification
The bench walks through all four mode codes while the reference runs. It also moves between oscillator-sourced modes and bypass, which tells the lock-wait path apart from the immediate bypass path. It then stops and restarts the reference under an oscillator mode, which separates the idle timeout and its release from ordinary mode decoding. A single mode step is timed edge by edge to pin down the synchronizer depth. The divider is run from both source clocks and gated by bank B enable, so that its phase reset and source choice both show.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;
  typedef enum logic [1:0] {
    MODE_OFF    = 2'b00,
    MODE_A_ONLY = 2'b01,
    MODE_BYPASS = 2'b10,
    MODE_BOTH   = 2'b11
  } buf_mode_e;
endpackage

// File: rtl/cb_sync.sv
module cb_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cb_rise_det.sv
module cb_rise_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic synced;
  logic prev;

  cb_sync #(.W(1), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(din), .q(synced)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= synced;
  end

  assign rise = synced & ~prev;
endmodule

// File: rtl/cb_idle_mon.sv
module cb_idle_mon #(
  parameter int IDLE_TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  output logic idle
);
  localparam int CW = $clog2(IDLE_TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(IDLE_TIMEOUT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (rise)         cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign idle = (cnt == LIMIT);

  // R7: a reference edge always releases power-down
  p_rise_clears_r7: assert property (@(posedge clk) disable iff (rst)
    rise |=> !idle);
  // R6: the last quiet cycle leads into power-down
  p_timeout_r6: assert property (@(posedge clk) disable iff (rst)
    (!rise && cnt == LIMIT - 1'b1) |=> idle);
endmodule

// File: rtl/cb_lock_timer.sv
module cb_lock_timer #(
  parameter int LOCK_WAIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic locked
);
  localparam int CW = $clog2(LOCK_WAIT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOCK_WAIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run)       cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign locked = (cnt == LIMIT);

  p_restart_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> !locked);
endmodule

// File: rtl/cb_half_div.sv
module cb_half_div (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic tick,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst || !en) q <= 1'b0;
    else if (tick)  q <= ~q;
  end

  p_div_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !en |=> !q);
  p_div_step_r10: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> (q != $past(q)));
endmodule

// File: rtl/clkbuf_mode_ctrl.sv
module clkbuf_mode_ctrl
  import clkbuf_pkg::*;
#(
  parameter int IDLE_TIMEOUT = 64,
  parameter int LOCK_WAIT    = 1024
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_clk,
  input  logic       pll_clk,
  input  logic [1:0] sel,
  input  logic       b_half_en,
  output logic       bank_a_oe,
  output logic       bank_b_oe,
  output logic       src_pll,
  output logic       pll_enable,
  output logic       bank_b_half
);
  logic [1:0] sel_sync;
  buf_mode_e  mode;
  logic       ref_rise, pll_rise, idle, locked, pll_run;
  logic       nxt_a, nxt_b;

  cb_sync #(.W(2), .STAGES(2)) u_sel_sync (
    .clk(clk), .rst(rst), .d(sel), .q(sel_sync)
  );
  cb_rise_det u_ref_edge (.clk(clk), .rst(rst), .din(ref_clk), .rise(ref_rise));
  cb_rise_det u_pll_edge (.clk(clk), .rst(rst), .din(pll_clk), .rise(pll_rise));

  cb_idle_mon #(.IDLE_TIMEOUT(IDLE_TIMEOUT)) u_idle (
    .clk(clk), .rst(rst), .rise(ref_rise), .idle(idle)
  );

  assign mode    = buf_mode_e'(sel_sync);
  assign pll_run = !idle && (mode == MODE_A_ONLY || mode == MODE_BOTH);

  cb_lock_timer #(.LOCK_WAIT(LOCK_WAIT)) u_lock (
    .clk(clk), .rst(rst), .run(pll_run), .locked(locked)
  );

  always_comb begin
    nxt_a = 1'b0;
    nxt_b = 1'b0;
    if (!idle) begin
      unique case (mode)
        MODE_OFF:    ;
        MODE_A_ONLY: nxt_a = locked;
        MODE_BYPASS: begin nxt_a = 1'b1; nxt_b = 1'b1; end
        MODE_BOTH:   begin nxt_a = locked; nxt_b = locked; end
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_a_oe  <= 1'b0;
      bank_b_oe  <= 1'b0;
      src_pll    <= 1'b0;
      pll_enable <= 1'b0;
    end else begin
      bank_a_oe  <= nxt_a;
      bank_b_oe  <= nxt_b;
      src_pll    <= pll_run;
      pll_enable <= pll_run;
    end
  end

  cb_half_div u_bdiv (
    .clk(clk), .rst(rst), .en(bank_b_oe && b_half_en),
    .tick(src_pll ? pll_rise : ref_rise), .q(bank_b_half)
  );

  p_pdown_r6: assert property (@(posedge clk) disable iff (rst)
    idle |=> (!bank_a_oe && !bank_b_oe && !pll_enable && !src_pll));
  p_b_implies_a_r5: assert property (@(posedge clk) disable iff (rst)
    bank_b_oe |-> bank_a_oe);
  p_bypass_r4: assert property (@(posedge clk) disable iff (rst)
    (bank_a_oe && !src_pll) |-> !pll_enable);
  p_lock_gate_r8: assert property (@(posedge clk) disable iff (rst)
    (pll_run && !locked) |=> !bank_a_oe);
endmodule

// File: tb/clkbuf_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkbuf_mode_ctrl_tb_top;
  localparam int TO = 20;
  localparam int LW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_clk = 1'b0, pll_clk = 1'b0;
  logic [1:0] sel = 2'b00;
  logic b_half_en = 1'b0;
  logic bank_a_oe, bank_b_oe, src_pll, pll_enable, bank_b_half;

  int checks = 0, fails = 0;
  bit ref_on = 1'b0;
  int ref_ph = 0, pll_ph = 0;

  always #2 clk = ~clk;

  clkbuf_mode_ctrl #(.IDLE_TIMEOUT(TO), .LOCK_WAIT(LW)) dut_i (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .pll_clk(pll_clk), .sel(sel),
    .b_half_en(b_half_en), .bank_a_oe(bank_a_oe), .bank_b_oe(bank_b_oe),
    .src_pll(src_pll), .pll_enable(pll_enable), .bank_b_half(bank_b_half)
  );

  // stimulus clocks: ref period 6 samples, pll period 4 samples
  always @(negedge clk) begin
    pll_ph = (pll_ph + 1) % 2;
    if (pll_ph == 0) pll_clk <= ~pll_clk;
    if (ref_on) begin
      ref_ph = (ref_ph + 1) % 3;
      if (ref_ph == 0) ref_clk <= ~ref_clk;
    end else begin
      ref_clk <= 1'b0;
    end
  end

  // behavioural reference model, written from the requirements
  int sel_q[$];
  int ref_q[$];
  int pll_q[$];
  int quiet = 0, lock_age = 0;
  bit m_a = 0, m_b = 0, m_src = 0, m_en = 0, m_half = 0;

  always @(posedge clk) begin
    if (rst) begin
      sel_q = {0, 0}; ref_q = {0, 0, 0}; pll_q = {0, 0, 0};
      quiet = 0; lock_age = 0;
      m_a = 0; m_b = 0; m_src = 0; m_en = 0; m_half = 0;
    end else begin
      int md;
      bit rr, pr, asleep, running, ready, tk;
      md      = sel_q[1];                          // R9: two sample stages
      rr      = (ref_q[1] == 1) && (ref_q[2] == 0); // R7: sync + edge
      pr      = (pll_q[1] == 1) && (pll_q[2] == 0);
      asleep  = (quiet >= TO);                     // R6
      running = !asleep && (md == 1 || md == 3);
      ready   = (lock_age >= LW);                  // R8
      tk      = m_src ? pr : rr;
      if (!(m_b && b_half_en)) m_half = 0;         // R10
      else if (tk) m_half = !m_half;
      m_a   = !asleep && (md == 2 || ((md == 1 || md == 3) && ready));
      m_b   = !asleep && (md == 2 || (md == 3 && ready));
      m_src = running;
      m_en  = running;
      quiet    = rr ? 0 : (quiet >= TO ? TO : quiet + 1);
      lock_age = !running ? 0 : (lock_age >= LW ? LW : lock_age + 1);
      sel_q.push_front(int'(sel)); void'(sel_q.pop_back());
      ref_q.push_front(int'(ref_clk)); void'(ref_q.pop_back());
      pll_q.push_front(int'(pll_clk)); void'(pll_q.pop_back());
    end
  end

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", tag, $time, got, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3/R5 bank_a_oe vs model", bank_a_oe, m_a);
      chk("R5 bank_b_oe vs model", bank_b_oe, m_b);
      chk("R8 pll_enable vs model", pll_enable, m_en);
      chk("R4 src_pll vs model", src_pll, m_src);
      chk("R10 bank_b_half vs model", bank_b_half, m_half);
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    int toggles;
    bit last;
    wait_cyc(4);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 bank_a_oe", bank_a_oe, 0); chk("R1 bank_b_oe", bank_b_oe, 0);
    chk("R1 pll_enable", pll_enable, 0); chk("R1 bank_b_half", bank_b_half, 0);
    ref_on = 1'b1;
    sel = 2'b11;
    wait_cyc(6);
    chk("R8 waiting for lock", bank_a_oe, 0);
    chk("R5 pll_enable", pll_enable, 1);
    wait_cyc(LW + 4);
    chk("R5 bank_a_oe", bank_a_oe, 1); chk("R5 bank_b_oe", bank_b_oe, 1);
    b_half_en = 1'b1;
    toggles = 0; last = bank_b_half;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (bank_b_half != last) toggles++;
      last = bank_b_half;
    end
    chk("R10 divider toggles on pll edges", toggles >= 8, 1);
    sel = 2'b01;
    wait_cyc(5);
    chk("R3 bank_b_oe", bank_b_oe, 0); chk("R3 bank_a_oe", bank_a_oe, 1);
    chk("R10 half held low with bank B off", bank_b_half, 0);
    sel = 2'b10;
    wait_cyc(5);
    chk("R4 bank_b_oe", bank_b_oe, 1); chk("R4 pll_enable", pll_enable, 0);
    chk("R4 src_pll", src_pll, 0);
    wait_cyc(30);
    // R9: timing of a single mode step
    sel = 2'b00;
    wait_cyc(2);
    chk("R9 unchanged after two edges", bank_a_oe, 1);
    wait_cyc(1);
    chk("R9 changed on third edge", bank_a_oe, 0);
    wait_cyc(3);
    chk("R2 bank_b_oe", bank_b_oe, 0); chk("R2 pll_enable", pll_enable, 0);
    sel = 2'b11;
    wait_cyc(LW + 10);
    ref_on = 1'b0;
    wait_cyc(TO + 8);
    chk("R6 bank_a_oe in power-down", bank_a_oe, 0);
    chk("R6 pll_enable in power-down", pll_enable, 0);
    sel = 2'b10;
    wait_cyc(6);
    chk("R6 bypass code still down", bank_a_oe, 0);
    ref_on = 1'b1;
    wait_cyc(10);
    chk("R7 released to bypass", bank_b_oe, 1);
    sel = 2'b11;
    wait_cyc(LW + 8);
    chk("R8 relocked", bank_a_oe, 1);
    wait_cyc(20);
    summary();
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: got running expected finished");
    summary();
  end
endmodule